// File: doc/BRIEF.md
# ADC Conversion Command Sequencer

This block sits between a host-facing serial slave and an external analog-to-digital converter. The host writes one command byte to set a conversion mode and, where the mode needs one, a channel. Every later read request from the host drives one step of a continuous read. The block starts a conversion on the channel that the mux select shows and waits for the converter to finish. It then hands the 10-bit result back as two bytes: the upper bits first, then the lower eight.

The command byte sets one of four modes. Single-channel mode converts one fixed channel again and again. Two scan modes walk the mux through channels 0 to 3 or 0 to 7. Differential mode measures one of the upper four channels against its paired sense input. The host ends a read with a stop indication. A stop blocks any further conversion request. A conversion already started still runs to completion, and its result is dropped.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, adcStart and rdValid are low, muxSel is 0 and diffMode is 0.
- R2: A read request while the block is idle gives a one-cycle adcStart pulse in the next cycle. At most one conversion is outstanding, so adcStart is never high in two consecutive cycles.
- R3: One cycle after adcDone, rdValid pulses and rdData holds {000000, result[9:8]}. The next read request makes rdValid pulse one cycle later with result[7:0].
- R4: Command code 000 in bits 7:5 sets muxSel to bits 2:0 with diffMode low, and the channel stays the same across repeated conversions.
- R5: Command code 001 scans channels 0, 1, 2, 3 and wraps back to 0. muxSel advances when each high byte is delivered.
- R6: Command code 011 scans channels 0 to 7 and wraps back to 0.
- R7: Command code 100 with bit 2 set gives muxSel = 4 + bits 1:0 and raises diffMode. Bits 4:3 are ignored.
- R8: Command codes 010, 101, 110 and 111, and code 100 with bit 2 clear, have no effect. muxSel, diffMode and the scan position keep their previous values.
- R9: Every accepted command load restarts a scan at channel 0.
- R10: hostStop or an accepted command load aborts the read. No result byte comes out of the conversion in flight, a pending low byte is dropped, and the scan position does not advance.
- R11: When hostStop arrives in the same cycle as adcDone, the result is discarded with no rdValid, and the channel does not advance.
- R12: After an abort, read requests are ignored until the conversion that was in flight reports adcDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdByte | input | 8 | Command byte: code in bits 7:5, channel in bits 2:0 |
| cmdLoad | input | 1 | Strobe that loads cmdByte |
| rdReq | input | 1 | Host asks for the next result byte |
| hostStop | input | 1 | Host ends the read |
| adcDone | input | 1 | Converter finished; adcResult valid |
| adcResult | input | 10 | Converter result |
| adcStart | output | 1 | One-cycle conversion start |
| muxSel | output | 3 | Analog mux channel select |
| diffMode | output | 1 | Differential measurement selected |
| rdData | output | 8 | Result byte toward the host |
| rdValid | output | 1 | rdData holds a new byte |

## Verification
The critical case is a host stop that lands in the same cycle as the converter's done pulse. A correct design lets the abort win: no byte appears and the channel pointer stays where it was. The bench provokes this by watching for adcDone between clock edges and raising hostStop in that same window. The scoreboard must then see no result byte, muxSel must be unchanged, and the next full read must return the channel that the aborted conversion had used. A second overlap tests a read request that arrives while an aborted conversion is draining. The bench judges it by counting converter starts.

// File: rtl/adc_conv_seq_pkg.sv
package adc_conv_seq_pkg;

  localparam int CH_W = 3;

  typedef enum logic [1:0] {
    MODE_SINGLE,
    MODE_SCAN4,
    MODE_SCAN8,
    MODE_DIFF
  } convMode_t;

  typedef struct packed {
    logic load;
    logic capture;
    logic emitLo;
  } seqStrb_t;

  typedef struct packed {
    convMode_t       mode;
    logic [CH_W-1:0] chan;
  } cmdDec_t;

  function automatic logic cmdIsValid(input logic [7:0] b);
    case (b[7:5])
      3'b000, 3'b001, 3'b011: cmdIsValid = 1'b1;
      3'b100:                 cmdIsValid = b[2];
      default:                cmdIsValid = 1'b0;
    endcase
  endfunction

  function automatic cmdDec_t decodeCmd(input logic [7:0] b);
    cmdDec_t d;
    d.mode = MODE_SINGLE;
    d.chan = b[CH_W-1:0];
    case (b[7:5])
      3'b001: begin d.mode = MODE_SCAN4; d.chan = '0; end
      3'b011: begin d.mode = MODE_SCAN8; d.chan = '0; end
      3'b100: begin d.mode = MODE_DIFF;  d.chan = {1'b1, b[1:0]}; end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/adc_conv_seq_ctrl.sv
module adc_conv_seq_ctrl
  import adc_conv_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdOk,
  input  logic     cmdLoad,
  input  logic     rdReq,
  input  logic     hostStop,
  input  logic     adcDone,
  output logic     adcStart,
  output seqStrb_t strb
);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_HAVELO, S_DRAIN} seqState_t;

  seqState_t state, stateNxt;
  logic      loadOk, abortReq, startNxt;

  always_comb begin
    loadOk       = cmdLoad & cmdOk;
    abortReq     = hostStop | loadOk;
    strb.load    = loadOk;
    strb.capture = (state == S_CONV) & adcDone & ~abortReq;
    strb.emitLo  = (state == S_HAVELO) & rdReq & ~abortReq;
    startNxt     = (state == S_IDLE) & rdReq & ~abortReq;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE:   if (startNxt) stateNxt = S_CONV;
      S_CONV: begin
        if (abortReq)     stateNxt = adcDone ? S_IDLE : S_DRAIN;
        else if (adcDone) stateNxt = S_HAVELO;
      end
      S_HAVELO: if (abortReq | rdReq) stateNxt = S_IDLE;
      S_DRAIN:  if (adcDone) stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      adcStart <= 1'b0;
    end else begin
      state    <= stateNxt;
      adcStart <= startNxt;
    end
  end

  // R2: the start is a single-cycle pulse
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R2: a start always follows a read request
  p_start_after_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> $past(rdReq));

  // R12: no start while a discarded conversion drains
  p_drain_no_start_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DRAIN) |=> !adcStart);

  // R11: a done that meets a stop never leads to a captured result
  p_stop_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CONV && hostStop && adcDone) |=> (state == S_IDLE));

endmodule

// File: rtl/adc_conv_seq_dp.sv
module adc_conv_seq_dp
  import adc_conv_seq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int BYTE_W     = 8,
  parameter int SCAN_SHORT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic [7:0]        cmdByte,
  input  logic [RES_W-1:0]  adcResult,
  output logic [CH_W-1:0]   muxSel,
  output logic              diffMode,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdValid
);

  localparam int HI_W   = RES_W - BYTE_W;
  localparam int NUM_CH = 1 << CH_W;

  convMode_t         mode;
  logic [CH_W-1:0]   chPtr, chNext;
  logic [BYTE_W-1:0] loByte;
  cmdDec_t           dec;

  assign dec = decodeCmd(cmdByte);

  always_comb begin
    chNext = chPtr;
    case (mode)
      MODE_SCAN4: chNext = (chPtr == CH_W'(SCAN_SHORT - 1)) ? '0 : chPtr + 1'b1;
      MODE_SCAN8: chNext = (chPtr == CH_W'(NUM_CH - 1)) ? '0 : chPtr + 1'b1;
      default:    chNext = chPtr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_SINGLE;
      chPtr    <= '0;
      diffMode <= 1'b0;
      loByte   <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      rdValid <= strb.capture | strb.emitLo;
      if (strb.load) begin
        mode     <= dec.mode;
        chPtr    <= dec.chan;
        diffMode <= (dec.mode == MODE_DIFF);
      end else if (strb.capture) begin
        chPtr  <= chNext;
        loByte <= adcResult[BYTE_W-1:0];
        rdData <= {{(BYTE_W-HI_W){1'b0}}, adcResult[RES_W-1:BYTE_W]};
      end else if (strb.emitLo) begin
        rdData <= loByte;
      end
    end
  end

  assign muxSel = chPtr;

  // R3: the first byte of a result carries only the top bits
  p_hi_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (rdValid && rdData[BYTE_W-1:HI_W] == '0));

  // R5: the short scan never leaves the lower channels
  p_scan4_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SCAN4) |-> (chPtr < CH_W'(SCAN_SHORT)));

  // R7: differential always pairs with an upper channel
  p_diff_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    diffMode |-> muxSel[CH_W-1]);

  // R4: fixed-channel modes hold the channel across a capture
  p_fixed_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && (mode == MODE_SINGLE || mode == MODE_DIFF)) |=> $stable(muxSel));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_conv_seq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int BYTE_W     = 8,
  parameter int SCAN_SHORT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        cmdByte,
  input  logic              cmdLoad,
  input  logic              rdReq,
  input  logic              hostStop,
  input  logic              adcDone,
  input  logic [RES_W-1:0]  adcResult,
  output logic              adcStart,
  output logic [CH_W-1:0]   muxSel,
  output logic              diffMode,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdValid
);

  seqStrb_t strb;
  logic     cmdOk;

  assign cmdOk = cmdIsValid(cmdByte);

  adc_conv_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdOk    (cmdOk),
    .cmdLoad  (cmdLoad),
    .rdReq    (rdReq),
    .hostStop (hostStop),
    .adcDone  (adcDone),
    .adcStart (adcStart),
    .strb     (strb)
  );

  adc_conv_seq_dp #(
    .RES_W      (RES_W),
    .BYTE_W     (BYTE_W),
    .SCAN_SHORT (SCAN_SHORT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmdByte   (cmdByte),
    .adcResult (adcResult),
    .muxSel    (muxSel),
    .diffMode  (diffMode),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

  // R10: a stop cycle is never followed by a result byte
  p_stop_no_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    hostStop |=> !rdValid);

  // R8: a rejected command load leaves the channel alone
  p_bad_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLoad && !cmdOk && !rdValid) |=> $stable(muxSel) && $stable(diffMode));

endmodule

// File: tb/adc_conv_seq_bench.sv
`timescale 1ns/100ps
module adc_conv_seq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cmdByte = '0;
  logic       cmdLoad = 1'b0, rdReq = 1'b0, hostStop = 1'b0, adcDone = 1'b0;
  logic [9:0] adcResult = '0;
  logic       adcStart, diffMode, rdValid;
  logic [2:0] muxSel;
  logic [7:0] rdData;

  always #2.5 clk = ~clk;

  adc_conv_seq u_adc_conv_seq (
    .clk(clk), .rstN(rstN), .cmdByte(cmdByte), .cmdLoad(cmdLoad),
    .rdReq(rdReq), .hostStop(hostStop), .adcDone(adcDone),
    .adcResult(adcResult), .adcStart(adcStart), .muxSel(muxSel),
    .diffMode(diffMode), .rdData(rdData), .rdValid(rdValid)
  );

  int    checks = 0, fails = 0;
  bit    finished = 0;
  string phase = "R1";
  logic [7:0] expQ[$];
  string      tagQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model: fixed latency, result tags diff, channel and start index
  int         latCnt = 0, startCnt = 0;
  logic [5:0] adcSeq = '0, seqHold = '0;
  logic [2:0] chHold = '0;
  logic       diffHold = 1'b0, prevStart = 1'b0;
  bit         dblStart = 0;

  always @(posedge clk) begin
    prevStart <= adcStart;
    if (adcStart && prevStart) dblStart <= 1;
    adcDone <= 1'b0;
    if (adcStart) begin
      latCnt   <= 3;
      seqHold  <= adcSeq;
      adcSeq   <= adcSeq + 1'b1;
      chHold   <= muxSel;
      diffHold <= diffMode;
      startCnt <= startCnt + 1;
    end else if (latCnt != 0) begin
      latCnt <= latCnt - 1;
      if (latCnt == 1) begin
        adcDone   <= 1'b1;
        adcResult <= {diffHold, chHold, seqHold};
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin : monitor
    logic [7:0] e;
    string      t;
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(0, {phase, " unexpected result byte"}, rdData, 0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData == e, t, rdData, e);
      end
    end
  end

  task automatic loadCmd(input logic [7:0] b);
    cmdByte = b; cmdLoad = 1'b1;
    @(negedge clk); cmdLoad = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseRd();
    rdReq = 1'b1; @(negedge clk); rdReq = 1'b0;
  endtask

  task automatic pulseStop();
    hostStop = 1'b1; @(negedge clk); hostStop = 1'b0;
  endtask

  task automatic waitQ(input int n, input string tag);
    int g = 0;
    while (expQ.size() > n && g < 40) begin
      @(negedge clk); #1; g++;
    end
    if (expQ.size() > n) begin
      check(0, {tag, " result byte missing"}, expQ.size(), n);
      while (expQ.size() > n) begin void'(expQ.pop_front()); void'(tagQ.pop_front()); end
    end
    @(negedge clk);
  endtask

  task automatic readSample(input logic [2:0] ch, input logic dif, input string tag);
    logic [9:0] r;
    r = {dif, ch, adcSeq};
    expQ.push_back({6'b0, r[9:8]}); tagQ.push_back({tag, " high byte"});
    expQ.push_back(r[7:0]);         tagQ.push_back({tag, " low byte"});
    pulseRd(); waitQ(1, tag);
    pulseRd(); waitQ(0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(adcStart == 0, "R1 adcStart", adcStart, 0);
    check(rdValid == 0, "R1 rdValid", rdValid, 0);
    check(muxSel == 0, "R1 muxSel", muxSel, 0);
    check(diffMode == 0, "R1 diffMode", diffMode, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 single channel 5, repeated
    phase = "R4";
    loadCmd(8'h05);
    check(muxSel == 5 && diffMode == 0, "R4 select", {diffMode, muxSel}, 5);
    readSample(3'd5, 1'b0, "R3 R4 single");
    readSample(3'd5, 1'b0, "R4 single repeat");
    check(muxSel == 5, "R4 hold", muxSel, 5);

    // R5 scan of four with wrap
    phase = "R5";
    loadCmd(8'h20);
    check(muxSel == 0, "R5 start", muxSel, 0);
    for (int i = 0; i < 5; i++) readSample(3'(i % 4), 1'b0, "R5 scan4");
    check(muxSel == 1, "R5 after wrap", muxSel, 1);

    // R8 rejected commands
    phase = "R8";
    loadCmd(8'h40);
    loadCmd(8'h80);
    loadCmd(8'hE7);
    loadCmd(8'hA4);
    check(muxSel == 1 && diffMode == 0, "R8 unchanged", {diffMode, muxSel}, 1);
    readSample(3'd1, 1'b0, "R8 scan continues");

    // R9 reload restarts
    phase = "R9";
    loadCmd(8'h20);
    check(muxSel == 0, "R9 restart", muxSel, 0);

    // R6 scan of eight with wrap
    phase = "R6";
    loadCmd(8'h60);
    for (int i = 0; i < 9; i++) readSample(3'(i % 8), 1'b0, "R6 scan8");
    check(muxSel == 1, "R6 after wrap", muxSel, 1);

    // R7 differential
    phase = "R7";
    loadCmd(8'h86);
    check(muxSel == 6 && diffMode == 1, "R7 pair 2", {diffMode, muxSel}, 8'hE);
    readSample(3'd6, 1'b1, "R7 diff");
    loadCmd(8'h9F);
    check(muxSel == 7 && diffMode == 1, "R7 bits 4:3 ignored", {diffMode, muxSel}, 8'hF);
    loadCmd(8'h80);
    check(muxSel == 7 && diffMode == 1, "R8 diff bit2 clear", {diffMode, muxSel}, 8'hF);
    readSample(3'd7, 1'b1, "R7 diff repeat");

    // R11 stop meets done
    phase = "R11";
    loadCmd(8'h60);
    readSample(3'd0, 1'b0, "R11 lead-in");
    pulseRd();
    for (int g = 0; g < 20 && !adcDone; g++) @(negedge clk);
    hostStop = 1'b1; @(negedge clk); hostStop = 1'b0;
    repeat (5) @(negedge clk);
    check(muxSel == 1, "R11 channel held", muxSel, 1);
    readSample(3'd1, 1'b0, "R11 retry");

    // R10 stop with low byte pending
    phase = "R10";
    expQ.push_back({6'b0, 1'b0, 1'b0}); tagQ.push_back("R10 high byte");
    pulseRd(); waitQ(0, "R10");
    pulseStop();
    repeat (6) @(negedge clk);
    check(muxSel == 3, "R10 advanced on high byte", muxSel, 3);
    readSample(3'd3, 1'b0, "R10 fresh read");

    // R10 R12 stop during conversion, read while draining
    phase = "R12";
    s0 = startCnt;
    pulseRd();
    pulseStop();
    pulseRd();
    repeat (10) @(negedge clk);
    check(startCnt == s0 + 1, "R12 starts during drain", startCnt - s0, 1);
    check(muxSel == 4, "R10 no advance on abort", muxSel, 4);
    readSample(3'd4, 1'b0, "R10 R12 after drain");

    check(dblStart == 0, "R2 single-cycle start", dblStart, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule